// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Extractor

This block recovers channel-associated signaling from a received T1 stream. Upstream framing logic hands it one channel octet per valid cycle. Each octet is tagged with a frame number (1 to 24), a channel number (1 to 24) and a flag that marks the first octet of a multiframe. In signaling frames the least significant bit of each octet carries one signaling bit for that channel. The block gathers these bits into a four-bit nibble per channel. The mode input chooses between 12-frame (A, B) and 24-frame (A, B, C, D) operation.

Bits are first collected in a shadow store. The visible copy changes only once per multiframe, in a single commit cycle. A processor-side reader and the per-timeslot control output therefore never see a nibble that is half from one multiframe and half from the next. Both destinations always receive the same data from that one visible copy. A global enable and a per-channel clear-channel mask decide which channels accept new nibbles at commit.

Sequencing is a three-state machine:
- S_HUNT waits for the multiframe flag. It moves to S_GATHER on a valid octet that has the flag set.
- S_GATHER captures bits. It moves to S_COMMIT on the valid octet of channel 24 in the last frame (frame 24 in ABCD mode, frame 12 in AB mode).
- S_COMMIT lasts one cycle and copies the shadow into the visible registers. It always returns to S_GATHER, so back-to-back multiframes need no further flag.

Top module: `t1_rbs_extract`

## Requirements
- R1: After a synchronous active-high reset, every channel's nibble reads 0 and the sequencer waits for a multiframe flag.
- R2: With mode16=1, a channel's nibble is {A,B,C,D}, with A in bit 3 and D in bit 0. A, B, C and D are bit 0 of that channel's octet in frames 6, 12, 18 and 24 respectively.
- R3: With mode16=0, the multiframe is 12 frames long. A is bit 0 of the octet in frame 6 and B is bit 0 of the octet in frame 12. The stored nibble is {A,B,A,B}.
- R4: The nibbles seen on both outputs change only in the cycle after the octet of channel 24 in the last frame has been accepted. Just before that cycle they still show the previous multiframe's values.
- R5: When rb_en is 0 at commit, no nibble changes.
- R6: A channel whose clear_chan bit is 1 at commit (bit i is channel i+1) keeps its previous nibble. The other channels update.
- R7: rd_nibble returns the nibble of channel rd_chan for values 1 to 24, and 0 for any other value.
- R8: Timeslot ts_index 0 to 23 carries channel ts_index+1 on ts_nibble with ts_oe=1. Timeslots 24 to 31 give ts_oe=0 and ts_nibble=0.
- R9: Octets that arrive before the first multiframe flag after reset are ignored, including the last octet of a multiframe, so no commit occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rb_en | input | 1 | Global signaling enable, sampled at commit |
| mode16 | input | 1 | 1 = 24-frame ABCD mode, 0 = 12-frame AB mode |
| clear_chan | input | 24 | Per-channel clear-channel mask, bit i = channel i+1 |
| in_valid | input | 1 | Octet valid |
| in_frame | input | 5 | Frame number, 1 to 24 |
| in_chan | input | 5 | Channel number, 1 to 24 |
| in_octet | input | 8 | Received channel octet |
| in_mf_sync | input | 1 | Marks the first octet of a multiframe |
| rd_chan | input | 5 | Register read channel select |
| rd_nibble | output | 4 | Nibble of the selected channel |
| ts_index | input | 5 | Control-stream timeslot, 0 to 31 |
| ts_nibble | output | 4 | Nibble placed in that timeslot |
| ts_oe | output | 1 | High when the timeslot carries a channel |

## Verification
The hardest case to reach is the commit boundary itself. The bench must show that a nibble keeps its old value in the one cycle after the last octet has been taken, and holds its new value one cycle later. To get there, it streams whole multiframes one octet per cycle with a distinct signaling pattern for each seed. It reads a channel in the S_COMMIT cycle before the visible registers load, then sweeps all channels and timeslots afterwards. The bench also streams a complete multiframe with no flag straight after reset, which shows that S_HUNT lets no commit through. Further runs switch modes and apply masks or the disabled enable across a multiframe.

// File: rtl/t1sig_pkg.sv
package t1sig_pkg;
    typedef enum logic [1:0] {
        S_HUNT   = 2'd0,
        S_GATHER = 2'd1,
        S_COMMIT = 2'd2
    } seq_state_t;

    typedef logic [3:0] nibble_t;

    localparam int NIB_W = 4;
endpackage

// File: rtl/t1sig_seq.sv
module t1sig_seq
    import t1sig_pkg::*;
#(
    parameter int NCH  = 24,
    parameter int NFRM = 24,
    parameter int FW   = $clog2(NFRM + 1),
    parameter int CW   = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode16,
    input  logic          in_valid,
    input  logic [FW-1:0] in_frame,
    input  logic [CW-1:0] in_chan,
    input  logic          in_mf_sync,
    output logic          cap_en,
    output logic          commit
);
    localparam int HALF = NFRM / 2;

    seq_state_t state_q, state_d;
    logic       last_octet;

    // end of multiframe: final channel of final frame for the selected mode
    assign last_octet = in_valid && (in_chan == CW'(NCH)) &&
                        (in_frame == (mode16 ? FW'(NFRM) : FW'(HALF)));

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_HUNT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                if (in_valid && in_mf_sync) begin
                    cap_en  = 1'b1;
                    state_d = S_GATHER;
                end
            end
            S_GATHER: begin
                cap_en = in_valid;
                if (last_octet) state_d = S_COMMIT;
            end
            S_COMMIT: begin
                commit  = 1'b1;
                cap_en  = in_valid;
                state_d = S_GATHER;
            end
            default: state_d = S_HUNT;
        endcase
    end

    // R4: a commit lasts exactly one cycle
    a_r4_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R9: no commit can follow a hunting cycle without a multiframe flag
    a_r9_hunt_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HUNT && !(in_valid && in_mf_sync)) |=> !commit);
endmodule

// File: rtl/t1sig_shadow.sv
module t1sig_shadow
    import t1sig_pkg::*;
#(
    parameter int NCH  = 24,
    parameter int NFRM = 24,
    parameter int FW   = $clog2(NFRM + 1),
    parameter int CW   = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_en,
    input  logic                  mode16,
    input  logic [FW-1:0]         in_frame,
    input  logic [CW-1:0]         in_chan,
    input  logic                  rob_bit,
    output logic [NCH-1:0][3:0]   sh
);
    localparam int STRIDE = NFRM / NIB_W;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = cap_en && (in_chan == CW'(ch + 1));
        for (genvar k = 0; k < NIB_W; k++) begin : g_letter
            logic letter_ok;
            // C and D exist only in the 24-frame mode
            if (k < 2) begin : g_ab
                assign letter_ok = 1'b1;
            end else begin : g_cd
                assign letter_ok = mode16;
            end
            always_ff @(posedge clk) begin
                if (rst)
                    sh[ch][NIB_W-1-k] <= 1'b0;
                else if (hit && letter_ok && in_frame == FW'((k + 1) * STRIDE))
                    sh[ch][NIB_W-1-k] <= rob_bit;
            end
        end
    end
endmodule

// File: rtl/t1sig_regfile.sv
module t1sig_regfile
    import t1sig_pkg::*;
#(
    parameter int NCH      = 24,
    parameter int TS_SLOTS = 32,
    parameter int TS_BASE  = 0,
    parameter int CW       = $clog2(NCH + 1),
    parameter int TW       = $clog2(TS_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic                rb_en,
    input  logic                mode16,
    input  logic [NCH-1:0]      clear_chan,
    input  logic [NCH-1:0][3:0] sh,
    input  logic [CW-1:0]       rd_chan,
    input  logic [TW-1:0]       ts_index,
    output logic [3:0]          rd_nibble,
    output logic [3:0]          ts_nibble,
    output logic                ts_oe
);
    logic [NCH-1:0][3:0] vis;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_vis
        always_ff @(posedge clk) begin
            if (rst)
                vis[ch] <= 4'd0;
            else if (commit && rb_en && !clear_chan[ch])
                vis[ch] <= mode16 ? sh[ch] : {sh[ch][3:2], sh[ch][3:2]};
        end

        // R6: a clear channel keeps its nibble across a commit
        a_r6_clear_keeps: assert property (@(posedge clk) disable iff (rst)
            (commit && clear_chan[ch]) |=> vis[ch] == $past(vis[ch]));

        // R3: in AB mode the low pair mirrors the high pair after commit
        a_r3_ab_mirror: assert property (@(posedge clk) disable iff (rst)
            (commit && rb_en && !clear_chan[ch] && !mode16) |=> vis[ch][1:0] == vis[ch][3:2]);
    end

    always_comb begin
        rd_nibble = 4'd0;
        ts_nibble = 4'd0;
        ts_oe     = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_chan == CW'(i + 1)) rd_nibble = vis[i];
            if (ts_index == TW'(TS_BASE + i)) begin
                ts_nibble = vis[i];
                ts_oe     = 1'b1;
            end
        end
    end

    // R4: between commits the visible copy is frozen
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(vis));

    // R5: a disabled commit changes nothing
    a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
        (commit && !rb_en) |=> $stable(vis));
endmodule

// File: rtl/t1_rbs_extract.sv
module t1_rbs_extract
    import t1sig_pkg::*;
#(
    parameter int NCH      = 24,
    parameter int NFRM     = 24,
    parameter int TS_SLOTS = 32,
    parameter int TS_BASE  = 0,
    parameter int FW       = $clog2(NFRM + 1),
    parameter int CW       = $clog2(NCH + 1),
    parameter int TW       = $clog2(TS_SLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rb_en,
    input  logic           mode16,
    input  logic [NCH-1:0] clear_chan,
    input  logic           in_valid,
    input  logic [FW-1:0]  in_frame,
    input  logic [CW-1:0]  in_chan,
    input  logic [7:0]     in_octet,
    input  logic           in_mf_sync,
    input  logic [CW-1:0]  rd_chan,
    output logic [3:0]     rd_nibble,
    input  logic [TW-1:0]  ts_index,
    output logic [3:0]     ts_nibble,
    output logic           ts_oe
);
    logic                cap_en;
    logic                commit;
    logic [NCH-1:0][3:0] sh;

    t1sig_seq #(.NCH(NCH), .NFRM(NFRM), .FW(FW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode16     (mode16),
        .in_valid   (in_valid),
        .in_frame   (in_frame),
        .in_chan    (in_chan),
        .in_mf_sync (in_mf_sync),
        .cap_en     (cap_en),
        .commit     (commit)
    );

    t1sig_shadow #(.NCH(NCH), .NFRM(NFRM), .FW(FW), .CW(CW)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .mode16   (mode16),
        .in_frame (in_frame),
        .in_chan  (in_chan),
        .rob_bit  (in_octet[0]),
        .sh       (sh)
    );

    t1sig_regfile #(.NCH(NCH), .TS_SLOTS(TS_SLOTS), .TS_BASE(TS_BASE),
                    .CW(CW), .TW(TW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .rb_en      (rb_en),
        .mode16     (mode16),
        .clear_chan (clear_chan),
        .sh         (sh),
        .rd_chan    (rd_chan),
        .ts_index   (ts_index),
        .rd_nibble  (rd_nibble),
        .ts_nibble  (ts_nibble),
        .ts_oe      (ts_oe)
    );
endmodule

// File: tb/test_t1_rbs_extract.sv
module test_t1_rbs_extract;
    logic        clk = 1'b0;
    logic        rst;
    logic        rb_en, mode16, in_valid, in_mf_sync;
    logic [23:0] clear_chan;
    logic [4:0]  in_frame, in_chan, rd_chan, ts_index;
    logic [7:0]  in_octet;
    logic [3:0]  rd_nibble, ts_nibble;
    logic        ts_oe;

    int total = 0;
    int fails = 0;
    logic [3:0] expv [1:24];

    always #2 clk = ~clk;

    t1_rbs_extract i_t1_rbs_extract (
        .clk(clk), .rst(rst), .rb_en(rb_en), .mode16(mode16),
        .clear_chan(clear_chan), .in_valid(in_valid), .in_frame(in_frame),
        .in_chan(in_chan), .in_octet(in_octet), .in_mf_sync(in_mf_sync),
        .rd_chan(rd_chan), .rd_nibble(rd_nibble), .ts_index(ts_index),
        .ts_nibble(ts_nibble), .ts_oe(ts_oe)
    );

    function automatic logic [3:0] pat(int c, int seed);
        return 4'((c * 5 + seed * 3 + 1) & 15);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 32; c++) begin
            rd_chan = 5'(c);
            #1;
            if (c >= 1 && c <= 24) chk(tag, $sformatf("rd ch%0d", c), rd_nibble, expv[c]);
            else                   chk("R7", $sformatf("rd ch%0d", c), rd_nibble, 0);
        end
        for (int t = 0; t < 32; t++) begin
            ts_index = 5'(t);
            #1;
            if (t < 24) begin
                chk("R8", $sformatf("oe ts%0d", t), ts_oe, 1);
                chk(tag, $sformatf("ts%0d", t), ts_nibble, expv[t + 1]);
            end else begin
                chk("R8", $sformatf("oe ts%0d", t), ts_oe, 0);
                chk("R8", $sformatf("idle ts%0d", t), ts_nibble, 0);
            end
        end
    endtask

    task automatic send_mf(bit m16, bit sync, int seed);
        int nf = m16 ? 24 : 12;
        mode16 = m16;
        for (int f = 1; f <= nf; f++) begin
            for (int c = 1; c <= 24; c++) begin
                logic lsb;
                logic [3:0] n = pat(c, seed);
                @(negedge clk);
                if (f % 6 == 0) lsb = n[3 - (f / 6 - 1)];
                else            lsb = 1'((c + f + seed) & 1);
                in_valid   = 1'b1;
                in_frame   = 5'(f);
                in_chan    = 5'(c);
                in_octet   = {7'((c * 13 + f * 7 + seed) & 127), lsb};
                in_mf_sync = sync && f == 1 && c == 1;
            end
        end
        @(negedge clk);
        in_valid   = 1'b0;
        in_mf_sync = 1'b0;
    endtask

    task automatic run_mf(bit m16, bit sync, int seed, bit en, logic [23:0] mask, string tag);
        rb_en = en;
        clear_chan = mask;
        send_mf(m16, sync, seed);
        // commit cycle: visible copy still old (R4)
        rd_chan = 5'd1;
        #1;
        chk("R4", "pre-commit ch1", rd_nibble, expv[1]);
        @(negedge clk);
        for (int c = 1; c <= 24; c++) begin
            logic [3:0] n = pat(c, seed);
            if (en && !mask[c - 1]) expv[c] = m16 ? n : {n[3:2], n[3:2]};
        end
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; rb_en = 1'b1; mode16 = 1'b1; clear_chan = '0;
        in_valid = 1'b0; in_frame = '0; in_chan = '0; in_octet = '0;
        in_mf_sync = 1'b0; rd_chan = '0; ts_index = '0;
        for (int c = 1; c <= 24; c++) expv[c] = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");
        // R9: full multiframe with no flag after reset is ignored
        send_mf(1'b1, 1'b0, 5);
        repeat (2) @(negedge clk);
        check_all("R9");
        // R2: ABCD mode, several patterns
        run_mf(1'b1, 1'b1, 1, 1'b1, 24'h0, "R2");
        run_mf(1'b1, 1'b0, 2, 1'b1, 24'h0, "R2");
        run_mf(1'b1, 1'b1, 3, 1'b1, 24'h0, "R2");
        // R3: AB mode
        run_mf(1'b0, 1'b0, 4, 1'b1, 24'h0, "R3");
        run_mf(1'b0, 1'b1, 6, 1'b1, 24'h0, "R3");
        // R5: disabled
        run_mf(1'b1, 1'b0, 7, 1'b0, 24'h0, "R5");
        // R6: clear-channel masks in both modes
        run_mf(1'b1, 1'b0, 8, 1'b1, 24'hA50F3C, "R6");
        run_mf(1'b0, 1'b0, 9, 1'b1, 24'h555555, "R6");
        run_mf(1'b1, 1'b0, 10, 1'b1, 24'hFFFFFF, "R6");
        // R1 again: reset clears stored nibbles
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 1; c <= 24; c++) expv[c] = 4'd0;
        check_all("R1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule